// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Movable Word Boundary

This block takes a one-bit serial stream, sampled on every rising edge of a fast bit clock, and packs it into parallel words of J bits. The ratio J is chosen while reset is held and stays fixed until the next reset. The supported ratios are 4, 7, 8 and 10, which use a shift register, and 1 and 2, which use a short capture pair instead. A position counter in the bit-clock domain divides time into word periods of J cycles. At one chosen position in each period, a load strobe copies the newest J bits into a staging register. At position 0 of every period, which plays the part of the slow word-clock edge, the staged word moves to the output register.

A receiver that has locked to the line uses the slip request to move the word boundary one bit at a time until its framing pattern lines up. Each period that contains at least one request moves the load point one position later, wrapping modulo J. The change applies from the next period. The stream keeps flowing and no word is ever cut short.

The output is a stream with a valid strobe and no ready. A serial line cannot be stalled, so the block accepts no back-pressure. Each word is on `word_o` for the single cycle that `word_vld_o` is high, and the downstream logic must take it in that cycle. `word_o` then holds the same value until the next strobe.

Top module: `serdes_rx_deser`

## Requirements
- R1: `ratio_i` is captured on every clock edge while `rst_n` is low. The values 1, 2, 4, 7, 8 and 10 select that J. Any other value acts exactly like 10.
- R2: Bits are packed MSB-first. Of the J bits in a word, the earliest received appears at `word_o[J-1]` and the latest at `word_o[0]`. Bits J and above are always 0.
- R3: Number the active edges 0, 1, 2 and so on from reset release, and take position p = edge mod J. With no slip requests, the load happens at position 2, or at position 0 when J is 1 or 2. A word therefore holds the bits sampled at the J edges that end with that load edge.
- R4: `slip_i` is sampled on every edge. Each word period with at least one request advances the load position by exactly one, modulo J, starting in the following period. Several requests in one period merge into a single step. One bit is skipped per step, and every emitted word still holds J consecutive bits.
- R5: No word is emitted from a load that happens before J bits have been sampled since reset release.
- R6: `word_vld_o` is a one-cycle pulse, and there is exactly one pulse per word period once the first word exists. Successive pulses are J cycles apart, so for J=1 the pulse is high every cycle. No complete word is lost or repeated.
- R7: A word loaded at edge t shows up, with `word_vld_o` high, just after edge (floor(t/J)+1)·J.
- R8: `word_o` changes only in a cycle where `word_vld_o` is high.
- R9: For J of 1 or 2 the shift register is not used. J=1 emits every sampled bit as its own word. J=2 emits pairs from a two-flop capture path that follows R2 and R3.
- R10: While `rst_n` is low, `word_vld_o` is 0 and `word_o` is 0. A reset also returns the load position to its default and clears pending slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_i | input | $clog2(MAX_J+1) | Requested ratio J, captured during reset |
| sdata_i | input | 1 | Serial data bit, sampled every edge |
| slip_i | input | 1 | Request to move the word boundary by one bit |
| word_o | output | MAX_J | Parallel word, with unused upper bits at 0 |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
Each word passes through two registers, so its due time depends on where its load edge falls. A word loaded at edge t is due just after edge (floor(t/J)+1)·J. That is one full period later when the load sits at position 0, and fewer cycles otherwise.

The driver models every edge from the requirements and queues each expected word with its due edge number. The monitor samples at the falling edge following each rising edge. It requires every strobe to match the head of the queue in both content and edge number, and it reports a word whose due edge has passed as missing. Slip requests are placed so that some straddle a period boundary and some fall inside one period, which exercises both the one-period deferral and the merging of requests.

// File: rtl/deser_pkg.sv
package deser_pkg;

  typedef enum logic {
    SRC_SHIFT  = 1'b0,
    SRC_BYPASS = 1'b1
  } src_e;

  // Map a requested ratio onto a supported one; unsupported requests fall back to max_j.
  function automatic int unsigned fit_ratio(input int unsigned req, input int unsigned max_j);
    case (req)
      1, 2, 4, 7, 8, 10: return (req <= max_j) ? req : max_j;
      default:           return max_j;
    endcase
  endfunction

  function automatic src_e pick_src(input int unsigned j);
    return (j <= 2) ? SRC_BYPASS : SRC_SHIFT;
  endfunction

endpackage

// File: rtl/deser_phase_ctrl.sv
module deser_phase_ctrl #(
  parameter int MAX_J    = 10,
  parameter int DEF_LOAD = 2,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_j,
  input  logic          slip_i,
  output logic [CW-1:0] pos_o,
  output logic [CW-1:0] offset_o,
  output logic          load_en_o,
  output logic          slow_en_o,
  output logic          full_o
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] DEFP = CW'(DEF_LOAD);

  logic [CW-1:0] pos, off, fill, def_pt, load_pt, last_pos;
  logic [CW:0]   sum;
  logic          pend, slip_now, at_last;

  assign last_pos = cfg_j - ONE;
  assign at_last  = (pos == last_pos);
  assign slip_now = pend | slip_i;

  // Default load point only applies when the period is long enough to hold it.
  assign def_pt  = (cfg_j > DEFP) ? DEFP : '0;
  assign sum     = {1'b0, def_pt} + {1'b0, off};
  assign load_pt = (sum >= {1'b0, cfg_j}) ? CW'(sum - {1'b0, cfg_j}) : sum[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      off  <= '0;
      fill <= '0;
      pend <= 1'b0;
    end else begin
      pos  <= at_last ? '0 : pos + ONE;
      pend <= at_last ? 1'b0 : slip_now;
      // Boundary moves only at the end of a period, so the next period is whole.
      if (at_last && slip_now)
        off <= (off == last_pos) ? '0 : off + ONE;
      if (fill != last_pos)
        fill <= fill + ONE;
    end
  end

  assign pos_o     = pos;
  assign offset_o  = off;
  assign load_en_o = (pos == load_pt);
  assign slow_en_o = (pos == '0);
  assign full_o    = (fill == last_pos);

endmodule

// File: rtl/deser_capture.sv
module deser_capture #(
  parameter int MAX_J     = 10,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata_i,
  input  logic             bypass_i,
  output logic [MAX_J-1:0] win_o
);
  logic [MAX_J-2:0] sr;
  logic             prev;

  // Long shift path; held still while the short path is in use.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (!bypass_i) begin
      sr[0] <= sdata_i;
      for (int k = 1; k < MAX_J - 1; k++) sr[k] <= sr[k-1];
    end
  end

  generate
    if (BYPASS_EN) begin : g_pair
      always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sdata_i;
      end
    end else begin : g_nopair
      assign prev = 1'b0;
    end
  endgenerate

  // Window includes the bit being sampled at this edge.
  assign win_o = bypass_i ? MAX_J'({prev, sdata_i}) : {sr, sdata_i};

endmodule

// File: rtl/deser_word_regs.sv
module deser_word_regs #(
  parameter int MAX_J = 10,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_j,
  input  logic [MAX_J-1:0] win_i,
  input  logic             load_en_i,
  input  logic             full_i,
  input  logic             slow_en_i,
  output logic [MAX_J-1:0] word_o,
  output logic             word_vld_o
);
  logic [MAX_J:0]   ext, ext_m1;
  logic [MAX_J-1:0] mask, stage;
  logic             stage_ok;

  assign ext    = (MAX_J+1)'(1) << cfg_j;
  assign ext_m1 = ext - (MAX_J+1)'(1);
  assign mask   = ext_m1[MAX_J-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage      <= '0;
      stage_ok   <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      if (load_en_i) begin
        stage <= win_i & mask;
        if (full_i) stage_ok <= 1'b1;
      end
      word_vld_o <= slow_en_i & stage_ok;
      if (slow_en_i && stage_ok) word_o <= stage;
    end
  end

endmodule

// File: rtl/serdes_rx_deser.sv
module serdes_rx_deser
  import deser_pkg::*;
#(
  parameter  int MAX_J    = 10,
  parameter  int DEF_LOAD = 2,
  localparam int CW       = $clog2(MAX_J + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    ratio_i,
  input  logic             sdata_i,
  input  logic             slip_i,
  output logic [MAX_J-1:0] word_o,
  output logic             word_vld_o
);
  logic [CW-1:0]    cfg_j, pos, offset;
  logic             load_en, slow_en, full;
  logic [MAX_J-1:0] win;
  src_e             src;

  // Ratio is configuration: captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_j <= CW'(fit_ratio(int'(ratio_i), MAX_J));
  end

  assign src = pick_src(int'(cfg_j));

  deser_phase_ctrl #(.MAX_J(MAX_J), .DEF_LOAD(DEF_LOAD), .CW(CW)) phase_i (
    .clk(clk), .rst_n(rst_n), .cfg_j(cfg_j), .slip_i(slip_i),
    .pos_o(pos), .offset_o(offset), .load_en_o(load_en),
    .slow_en_o(slow_en), .full_o(full)
  );

  deser_capture #(.MAX_J(MAX_J), .BYPASS_EN(1'b1)) cap_i (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata_i),
    .bypass_i(src == SRC_BYPASS), .win_o(win)
  );

  deser_word_regs #(.MAX_J(MAX_J), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_j(cfg_j), .win_i(win),
    .load_en_i(load_en), .full_i(full), .slow_en_i(slow_en),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

endmodule

// File: rtl/deser_rx_chk.sv
module deser_rx_chk #(
  parameter int MAX_J = 10,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    cfg,
  input logic [CW-1:0]    pos,
  input logic [CW-1:0]    offset,
  input logic [MAX_J-1:0] word_o,
  input logic             word_vld_o
);
  logic [CW:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (word_vld_o) begin
      gap  <= (CW+1)'(1);
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + (CW+1)'(1);
    end
  end

  // R6: strobes are exactly one period apart
  a_r6_strobe_period: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && seen) |-> (gap == {1'b0, cfg}));

  // R2: bits above the ratio stay clear
  a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> ((word_o >> cfg) == '0));

  // R8: word held between strobes
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o));

  // R4: boundary offset moves only right after the last position of a period
  a_r4_slip_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (offset != $past(offset)) |-> ($past(pos) == ($past(cfg) - CW'(1))));

  // R10: outputs still cleared in the first cycle after release
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!word_vld_o && word_o == '0));

endmodule

bind serdes_rx_deser deser_rx_chk #(.MAX_J(MAX_J), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_j), .pos(pos), .offset(offset),
  .word_o(word_o), .word_vld_o(word_vld_o)
);

// File: tb/serdes_rx_deser_tb_top.sv
module serdes_rx_deser_tb_top;
  localparam int MAX_J = 10;
  localparam int CW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CW-1:0]    ratio = CW'(10);
  logic             sdata = 1'b0;
  logic             slip = 1'b0;
  logic [MAX_J-1:0] word;
  logic             vld;

  always #5 clk = ~clk;

  serdes_rx_deser #(.MAX_J(MAX_J)) dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio), .sdata_i(sdata),
    .slip_i(slip), .word_o(word), .word_vld_o(vld)
  );

  typedef struct {
    logic [MAX_J-1:0] w;
    int               due;
  } exp_t;

  exp_t             q[$];
  exp_t             head;
  int               checks = 0;
  int               errors = 0;
  int               ecount = 0;
  int               tnow;
  int               cur_j = 10;
  int               first_seen = -1;
  logic             mon_en = 1'b0;
  logic             done = 1'b0;
  string            tag = "R3";
  logic [MAX_J-1:0] last_word = '0;

  task automatic fail(input string req, input string what, input longint act, input longint expv);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
  endtask

  // R1: supported ratios kept, anything else treated as 10
  function automatic int model_j(input int r);
    case (r)
      1, 2, 4, 7, 8, 10: return r;
      default:           return 10;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) ecount++;
    else       ecount = 0;
  end

  // Monitor: samples after each active edge
  always @(negedge clk) begin
    if (mon_en) begin
      tnow = ecount - 1;
      if (vld) begin
        checks++;
        if (q.size() == 0) begin
          fail("R6", "unexpected strobe", longint'(tnow), -1);
        end else begin
          head = q.pop_front();
          if (word !== head.w) fail(tag, "word content", longint'(word), longint'(head.w));
          checks++;
          if (head.due != tnow) fail("R7", "strobe edge", longint'(tnow), longint'(head.due));
          checks++;
          if ((word >> cur_j) != '0) fail("R2", "upper bits", longint'(word), 0);
          if (first_seen < 0) first_seen = tnow;
        end
      end else begin
        if (q.size() > 0 && q[0].due < tnow) begin
          checks++;
          fail("R6", "missing word", longint'(tnow), longint'(q[0].due));
          void'(q.pop_front());
        end
        checks++;
        if (word !== last_word) fail("R8", "word changed without strobe", longint'(word), longint'(last_word));
      end
      last_word = word;
    end
  end

  // Driver: drives one bit per edge and queues expected words from the requirements
  task automatic run(input int req_j, input int ncyc, input int slip_per, input int pat, input string rtag);
    int          j;
    int          off;
    int          pos;
    int          lp;
    int          first_due;
    logic        pend;
    logic        b;
    logic        sl;
    logic        slip_now;
    logic [15:0] lf;
    logic        bits [0:1023];
    exp_t        e;
    j = model_j(req_j);
    off = 0;
    pend = 1'b0;
    first_due = -1;
    lf = 16'hACE1 ^ 16'(pat * 77 + req_j);
    @(negedge clk);
    rst_n = 1'b0;
    mon_en = 1'b0;
    ratio = CW'(req_j);
    slip = 1'b0;
    sdata = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    checks++; // R10
    if (vld !== 1'b0 || word !== '0) fail("R10", "outputs in reset", longint'({vld, word}), 0);
    tag = rtag;
    cur_j = j;
    first_seen = -1;
    last_word = '0;
    rst_n = 1'b1;
    mon_en = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      if (t > 0) @(negedge clk);
      case (pat)
        1:       b = t[0];
        2:       b = ((t % 13) == 0);
        default: begin lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; b = lf[0]; end
      endcase
      sl = (slip_per > 0) && (t >= 2 * j) && ((t % slip_per) <= 1);
      sdata = b;
      slip = sl;
      bits[t] = b;
      // model of edge t
      pos = t % j;
      lp = (((j > 2) ? 2 : 0) + off) % j;
      if (pos == lp && t >= j - 1) begin
        e.w = '0;
        for (int i = 0; i < j; i++) e.w[j-1-i] = bits[t-j+1+i];
        e.due = (t / j + 1) * j;
        if (first_due < 0) first_due = e.due;
        q.push_back(e);
      end
      slip_now = pend | sl;
      if (pos == j - 1) begin
        if (slip_now) off = (off + 1) % j;
        pend = 1'b0;
      end else begin
        pend = slip_now;
      end
    end
    @(negedge clk);
    #1;
    mon_en = 1'b0;
    slip = 1'b0;
    while (q.size() > 0) begin
      head = q.pop_front();
      if (head.due <= ncyc - 1) begin
        checks++;
        fail("R6", "word never emitted", -1, longint'(head.due));
      end
    end
    checks++; // R5: first word only after J bits
    if (first_seen != first_due) fail("R5", "first strobe edge", longint'(first_seen), longint'(first_due));
  endtask

  initial begin
    run(10, 300, 0,  0, "R3");
    run(10, 400, 37, 0, "R4");
    run(7,  300, 29, 1, "R4");
    run(4,  200, 0,  2, "R3");
    run(8,  300, 23, 0, "R4");
    run(2,  120, 9,  0, "R9");
    run(1,  60,  0,  0, "R9");
    run(5,  200, 0,  2, "R1");
    run(15, 150, 0,  0, "R1");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule